// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a word-wide requester and a line-wide memory port. A request carries a byte address, a read/write flag and, for writes, one data word. The address selects one set, and both ways of that set have their tags compared in the same cycle. A match is answered one cycle after the request is taken, without touching memory. A write hit changes the word in place and marks the line modified.

On a miss the block picks one way of the set to reuse. An empty way is used first. If both ways hold lines and exactly one is modified, the unmodified one is replaced, even when it was used more recently. Otherwise a per-set recency bit names the way used less recently. A modified victim is first sent to memory as a whole line. The wanted line is then read in, the pending write word (if any) is merged into it, and the response is returned. Only one request is handled at a time. The request side is not ready while a miss is in progress.

Top module: `cache2w_top`

## Requirements
- R1: A request whose tag matches a valid way of its set gets `resp_valid` exactly one cycle after acceptance, with no memory request.
- R2: Address fields with defaults: word select is bits [3:2], set index is bits [7:4], tag is bits [15:8]. A line may occupy either way of its set, and two different tags of one set can be resident together.
- R3: On a miss in a set with an empty way, an empty way receives the line (way 0 before way 1), and nothing is written back.
- R4: When both ways are valid and equally clean or equally modified, the way not touched most recently (hits and fills both count as touches) is replaced.
- R5: When both ways are valid and exactly one is modified, the unmodified way is replaced and no writeback occurs.
- R6: A modified victim is written to memory (`mem_we`=1, line address = victim tag concatenated with set index, full line data) before the fill read starts, and the slot is clean afterwards.
- R7: A write hit replaces one word and marks the line modified. A write miss fills the line and then merges the word, leaving the other words as read from memory.
- R8: A read always returns the most recent data written to that address, including data that went through eviction and refill.
- R9: A memory request keeps address and direction stable until `mem_ack`, and `req_ready` is low while any memory request is outstanding.
- R10: After reset all lines are invalid, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write one word, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Write word |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | WORD_W | Read word (writes echo the written word) |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = line writeback, 0 = line fill read |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wdata | output | LINE_W | Line being written back |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | LINE_W | Fill line, valid with `mem_ack` |

## Verification
The hardest case to reach is a full set where exactly one line is modified and the recency bit points at that modified line. Only then does the clean-line preference change the outcome. The stimulus builds this state in set 0: two lines are filled, one of them is written, and the other is then read so that recency favours evicting the modified one. A third tag then misses. The bench checks that the writeback count stays put and that the modified line still hits. A later sequence dirties both ways so that recency alone decides and a writeback with a known line address must appear.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_EVICT  = 2'd1,
      ST_REFILL = 2'd2
   } cstate_e;

endpackage

// File: rtl/cache2w_way.sv
// One way of the cache: tag, valid, modified flag and line data per set.
// Read is combinational, write is a single full-entry port.
module cache2w_way #(
   parameter int unsigned NUM_SETS = 16,
   parameter int unsigned TAG_W    = 8,
   parameter int unsigned LINE_W   = 128,
   localparam int unsigned IDX_W   = $clog2(NUM_SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line,
   input  logic              wr_dirty
);

   logic [NUM_SETS-1:0] valid_q;
   logic [NUM_SETS-1:0] dirty_q;
   logic [TAG_W-1:0]    tag_q  [NUM_SETS];
   logic [LINE_W-1:0]   line_q [NUM_SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/cache2w_lru.sv
// One recency bit per set, naming the way to evict next.
module cache2w_lru #(
   parameter int unsigned NUM_SETS = 16,
   localparam int unsigned IDX_W   = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_evict,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_used
);

   logic [NUM_SETS-1:0] evict_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         evict_q <= '0;
      else if (upd_en)
         evict_q[upd_idx] <= ~upd_used;
   end

   assign rd_evict = evict_q[rd_idx];

endmodule

// File: rtl/cache2w_victim.sv
// Victim choice: empty way first, then (optionally) clean over modified,
// then the recency bit.
module cache2w_victim #(
   parameter bit PREFER_CLEAN = 1'b1
) (
   input  logic [1:0] valid,
   input  logic [1:0] dirty,
   input  logic       lru_evict,
   output logic       victim
);

   generate
      if (PREFER_CLEAN) begin : g_clean_pref
         always_comb begin
            if (!valid[0])
               victim = 1'b0;
            else if (!valid[1])
               victim = 1'b1;
            else if (dirty[0] != dirty[1])
               victim = dirty[0];
            else
               victim = lru_evict;
         end
      end else begin : g_plain_lru
         logic unused_dirty;
         assign unused_dirty = ^dirty;
         always_comb begin
            if (!valid[0])
               victim = 1'b0;
            else if (!valid[1])
               victim = 1'b1;
            else
               victim = lru_evict;
         end
      end
   endgenerate

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
   import cache2w_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned LINE_BYTES   = 16,
   parameter int unsigned NUM_SETS     = 16,
   parameter bit          PREFER_CLEAN = 1'b1,
   localparam int unsigned OFF_W   = $clog2(LINE_BYTES),
   localparam int unsigned LINE_W  = LINE_BYTES * 8,
   localparam int unsigned LADDR_W = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WORD_W-1:0]  req_wdata,
   output logic               resp_valid,
   output logic [WORD_W-1:0]  resp_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [LINE_W-1:0]  mem_rdata
);

   localparam int unsigned WORDS  = LINE_W / WORD_W;
   localparam int unsigned WSEL_W = $clog2(WORDS);
   localparam int unsigned BSEL_W = $clog2(WORD_W / 8);
   localparam int unsigned IDX_W  = $clog2(NUM_SETS);
   localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;

   initial begin : elab_chk
      assert (NUM_SETS >= 2 && (NUM_SETS & (NUM_SETS - 1)) == 0)
         else $error("NUM_SETS must be a power of two, at least 2");
      assert (WORD_W >= 8 && (WORD_W & (WORD_W - 1)) == 0)
         else $error("WORD_W must be a power of two byte multiple");
      assert (WORDS >= 2 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("line must be a power of two holding two or more words");
      assert (ADDR_W > OFF_W + IDX_W)
         else $error("ADDR_W leaves no tag bits");
   end

   function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                   input logic [WSEL_W-1:0] s);
      return l[int'(s)*WORD_W +: WORD_W];
   endfunction

   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                  input logic [WSEL_W-1:0] s,
                                                  input logic [WORD_W-1:0] d);
      logic [LINE_W-1:0] r;
      r = l;
      r[int'(s)*WORD_W +: WORD_W] = d;
      return r;
   endfunction

   // ------------------------------------------------------------------
   // Address split and latched miss context
   // ------------------------------------------------------------------
   cstate_e            state_q;
   logic [TAG_W-1:0]   lat_tag;
   logic [IDX_W-1:0]   lat_idx;
   logic [WSEL_W-1:0]  lat_wsel;
   logic               lat_write;
   logic [WORD_W-1:0]  lat_wdata;
   logic               lat_victim;

   logic [TAG_W-1:0]   in_tag;
   logic [IDX_W-1:0]   in_idx;
   logic [WSEL_W-1:0]  in_wsel;
   logic               unused_bsel;

   assign in_tag      = req_addr[ADDR_W-1 -: TAG_W];
   assign in_idx      = req_addr[OFF_W +: IDX_W];
   assign in_wsel     = req_addr[BSEL_W +: WSEL_W];
   assign unused_bsel = ^req_addr[BSEL_W-1:0];

   logic             accept;
   logic [IDX_W-1:0] rd_idx;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign rd_idx    = (state_q == ST_IDLE) ? in_idx : lat_idx;

   // ------------------------------------------------------------------
   // Ways
   // ------------------------------------------------------------------
   logic [1:0]        way_valid;
   logic [1:0]        way_dirty;
   logic [TAG_W-1:0]  way_tag  [2];
   logic [LINE_W-1:0] way_line [2];
   logic [1:0]        hit_vec;

   logic              wr_en;
   logic              wr_way;
   logic [TAG_W-1:0]  wr_tag;
   logic [LINE_W-1:0] wr_line;
   logic              wr_dirty;

   generate
      for (genvar w = 0; w < 2; w++) begin : g_way
         cache2w_way #(
            .NUM_SETS (NUM_SETS),
            .TAG_W    (TAG_W),
            .LINE_W   (LINE_W)
         ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (rd_idx),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .rd_tag   (way_tag[w]),
            .rd_line  (way_line[w]),
            .wr_en    (wr_en && (wr_way == 1'(w))),
            .wr_idx   (rd_idx),
            .wr_tag   (wr_tag),
            .wr_line  (wr_line),
            .wr_dirty (wr_dirty)
         );
         assign hit_vec[w] = way_valid[w] && (way_tag[w] == in_tag);
      end
   endgenerate

   logic              lookup_hit;
   logic              hit_way;
   logic [LINE_W-1:0] hit_line;

   assign lookup_hit = |hit_vec;
   assign hit_way    = hit_vec[1];
   assign hit_line   = way_line[hit_way];

   // ------------------------------------------------------------------
   // Recency and victim choice
   // ------------------------------------------------------------------
   logic lru_evict;
   logic upd_en;
   logic upd_used;
   logic victim;

   assign upd_en   = (accept && lookup_hit) || (state_q == ST_REFILL && mem_ack);
   assign upd_used = (state_q == ST_IDLE) ? hit_way : lat_victim;

   cache2w_lru #(
      .NUM_SETS (NUM_SETS)
   ) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_evict (lru_evict),
      .upd_en   (upd_en),
      .upd_idx  (rd_idx),
      .upd_used (upd_used)
   );

   cache2w_victim #(
      .PREFER_CLEAN (PREFER_CLEAN)
   ) u_victim (
      .valid     (way_valid),
      .dirty     (way_dirty),
      .lru_evict (lru_evict),
      .victim    (victim)
   );

   logic              new_vic_valid;
   logic              new_vic_dirty;
   logic [TAG_W-1:0]  vic_tag;
   logic [LINE_W-1:0] vic_line;
   logic              vic_valid;
   logic              vic_dirty;

   assign new_vic_valid = way_valid[victim];
   assign new_vic_dirty = way_dirty[victim];
   assign vic_tag       = way_tag[lat_victim];
   assign vic_line      = way_line[lat_victim];
   assign vic_valid     = way_valid[lat_victim];
   assign vic_dirty     = way_dirty[lat_victim];

   // ------------------------------------------------------------------
   // Way write port
   // ------------------------------------------------------------------
   always_comb begin
      wr_en    = 1'b0;
      wr_way   = 1'b0;
      wr_tag   = lat_tag;
      wr_line  = vic_line;
      wr_dirty = 1'b0;
      if (accept && lookup_hit && req_write) begin
         wr_en    = 1'b1;
         wr_way   = hit_way;
         wr_tag   = in_tag;
         wr_line  = put_word(hit_line, in_wsel, req_wdata);
         wr_dirty = 1'b1;
      end else if (state_q == ST_EVICT && mem_ack) begin
         wr_en    = 1'b1;
         wr_way   = lat_victim;
         wr_tag   = vic_tag;
         wr_line  = vic_line;
         wr_dirty = 1'b0;
      end else if (state_q == ST_REFILL && mem_ack) begin
         wr_en    = 1'b1;
         wr_way   = lat_victim;
         wr_tag   = lat_tag;
         wr_line  = lat_write ? put_word(mem_rdata, lat_wsel, lat_wdata) : mem_rdata;
         wr_dirty = lat_write;
      end
   end

   // ------------------------------------------------------------------
   // Control sequence
   // ------------------------------------------------------------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         resp_valid <= 1'b0;
         resp_rdata <= '0;
         lat_tag    <= '0;
         lat_idx    <= '0;
         lat_wsel   <= '0;
         lat_write  <= 1'b0;
         lat_wdata  <= '0;
         lat_victim <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (lookup_hit) begin
                     resp_valid <= 1'b1;
                     resp_rdata <= req_write ? req_wdata : pick_word(hit_line, in_wsel);
                  end else begin
                     lat_tag    <= in_tag;
                     lat_idx    <= in_idx;
                     lat_wsel   <= in_wsel;
                     lat_write  <= req_write;
                     lat_wdata  <= req_wdata;
                     lat_victim <= victim;
                     state_q    <= (new_vic_valid && new_vic_dirty) ? ST_EVICT : ST_REFILL;
                  end
               end
            end
            ST_EVICT: begin
               if (mem_ack)
                  state_q <= ST_REFILL;
            end
            ST_REFILL: begin
               if (mem_ack) begin
                  resp_valid <= 1'b1;
                  resp_rdata <= lat_write ? lat_wdata : pick_word(mem_rdata, lat_wsel);
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_EVICT);
   assign mem_addr  = (state_q == ST_EVICT) ? {vic_tag, lat_idx} : {lat_tag, lat_idx};
   assign mem_wdata = vic_line;

   // ------------------------------------------------------------------
   // Assertions
   // ------------------------------------------------------------------
   a_r1_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      accept && lookup_hit |=> resp_valid && !mem_req);

   a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> $onehot0(hit_vec));

   a_r3_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !lookup_hit && !(&way_valid) |-> !new_vic_valid);

   generate
      if (PREFER_CLEAN) begin : g_clean_chk
         a_r5_clean_chosen: assert property (@(posedge clk) disable iff (!rst_n)
            accept && !lookup_hit && (&way_valid) && (way_dirty[0] != way_dirty[1])
            |-> !new_vic_dirty);
      end
   endgenerate

   a_r6_clean_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_REFILL |-> !(vic_valid && vic_dirty));

   a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

endmodule

// File: tb/cache2w_top_test.sv
module cache2w_top_test;

   localparam int ADDR_W = 16;
   localparam int WORD_W = 32;
   localparam int LINE_W = 128;
   localparam int LA_W   = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [WORD_W-1:0] req_wdata = '0;
   logic              resp_valid;
   logic [WORD_W-1:0] resp_rdata;
   logic              mem_req;
   logic              mem_we;
   logic [LA_W-1:0]   mem_addr;
   logic [LINE_W-1:0] mem_wdata;
   logic              mem_ack = 1'b0;
   logic [LINE_W-1:0] mem_rdata = '0;

   always #2 clk = ~clk;

   cache2w_top uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int total = 0;
   int failed = 0;
   int cyc = 0;
   int fills = 0;
   int wbs = 0;
   int r9_bad = 0;
   int last_lat = 0;
   logic [LA_W-1:0]   last_wb_addr = '0;
   logic [LINE_W-1:0] last_wb_data = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] init_word(input logic [LA_W-1:0] la, input logic [1:0] w);
      return {4'hA, la, 10'h1F3, 4'h0, w};
   endfunction

   // memory model
   logic [LINE_W-1:0] mem [int];
   logic [31:0]       refm [int];

   function automatic logic [LINE_W-1:0] mem_line(input logic [LA_W-1:0] la);
      logic [LINE_W-1:0] l;
      if (mem.exists(int'(la))) return mem[int'(la)];
      for (int w = 0; w < 4; w++) l[w*32 +: 32] = init_word(la, 2'(w));
      return l;
   endfunction

   function automatic logic [31:0] ref_rd(input logic [15:0] a);
      if (refm.exists(int'(a[15:2]))) return refm[int'(a[15:2])];
      return init_word(a[15:4], a[3:2]);
   endfunction

   initial begin : mem_responder
      int wait_cnt = 0;
      bit pend = 1'b0;
      logic [LA_W-1:0] p_addr = '0;
      logic p_we = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (pend && (mem_addr !== p_addr || mem_we !== p_we)) r9_bad++;
            if (req_ready) r9_bad++;
            pend = 1'b1; p_addr = mem_addr; p_we = mem_we;
            wait_cnt++;
            if (wait_cnt == 3) begin
               wait_cnt = 0; pend = 1'b0;
               if (mem_we) begin
                  mem[int'(mem_addr)] = mem_wdata;
                  wbs++; last_wb_addr = mem_addr; last_wb_data = mem_wdata;
               end else begin
                  mem_rdata = mem_line(mem_addr);
                  fills++;
               end
               mem_ack = 1'b1;
            end
         end
      end
   end

   // scoreboard
   typedef struct {
      bit          chk;
      logic [31:0] exp;
      string       rq;
      int          t0;
   } item_t;
   item_t exp_q[$];

   initial begin : monitor
      item_t it;
      forever begin
         @(negedge clk);
         if (resp_valid) begin
            if (exp_q.size() == 0) check("R8 unexpected response", 32'd1, 32'd0);
            else begin
               it = exp_q.pop_front();
               last_lat = cyc - it.t0;
               if (it.chk) check(it.rq, resp_rdata, it.exp);
            end
         end
      end
   end

   task automatic issue(input bit wr, input logic [15:0] a, input logic [31:0] d, input string rq);
      item_t it;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      it.chk = !wr; it.exp = ref_rd(a); it.rq = rq; it.t0 = cyc;
      if (wr) refm[int'(a[15:2])] = d;
      exp_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   function automatic logic [15:0] mk(input logic [7:0] tag, input logic [3:0] idx, input logic [1:0] w);
      return {tag, idx, w, 2'b00};
   endfunction

   bit done = 1'b0;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         check("watchdog expired", 32'd1, 32'd0);
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin : driver
      logic [15:0] lf = 16'hACE1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 req_ready", 32'(req_ready), 32'd1);
      check("R10 resp_valid", 32'(resp_valid), 32'd0);
      check("R10 mem_req", 32'(mem_req), 32'd0);

      issue(1'b0, mk(8'h01, 4'h0, 2'd1), '0, "R8 read A cold");
      check("R2 fill on cold miss", 32'(fills), 32'd1);
      issue(1'b0, mk(8'h01, 4'h0, 2'd2), '0, "R1 read A hit");
      check("R1 no fill on hit", 32'(fills), 32'd1);
      check("R1 hit latency", 32'(last_lat), 32'd1);

      issue(1'b0, mk(8'h02, 4'h0, 2'd0), '0, "R3 read B");
      issue(1'b0, mk(8'h01, 4'h0, 2'd0), '0, "R3 read A");
      issue(1'b0, mk(8'h02, 4'h0, 2'd3), '0, "R3 read B");
      check("R3 both tags resident", 32'(fills), 32'd2);
      check("R3 no writeback", 32'(wbs), 32'd0);

      issue(1'b0, mk(8'h03, 4'h0, 2'd0), '0, "R4 read C");
      check("R4 C filled", 32'(fills), 32'd3);
      issue(1'b0, mk(8'h02, 4'h0, 2'd1), '0, "R4 read B");
      check("R4 B kept", 32'(fills), 32'd3);
      issue(1'b0, mk(8'h01, 4'h0, 2'd1), '0, "R4 read A");
      check("R4 A was evicted", 32'(fills), 32'd4);

      // B modified, A touched last, LRU names B
      issue(1'b1, mk(8'h02, 4'h0, 2'd0), 32'hDEAD0001, "R7 write B hit");
      check("R7 write hit no fill", 32'(fills), 32'd4);
      issue(1'b0, mk(8'h01, 4'h0, 2'd2), '0, "R5 read A");
      issue(1'b0, mk(8'h04, 4'h0, 2'd2), '0, "R5 read D");
      check("R5 no writeback", 32'(wbs), 32'd0);
      issue(1'b0, mk(8'h02, 4'h0, 2'd0), '0, "R7 read B written word");
      check("R5 dirty B kept", 32'(fills), 32'd5);

      // both dirty -> LRU decides (B touched last was B, then write D)
      issue(1'b1, mk(8'h04, 4'h0, 2'd3), 32'hBEEF0002, "R7 write D hit");
      issue(1'b0, mk(8'h05, 4'h0, 2'd1), '0, "R6 read E");
      check("R6 one writeback", 32'(wbs), 32'd1);
      check("R6 writeback address", 32'(last_wb_addr), 32'h020);
      check("R6 writeback data", last_wb_data[31:0], 32'hDEAD0001);
      check("R6 writeback other word", last_wb_data[63:32], init_word(12'h020, 2'd1));
      issue(1'b0, mk(8'h02, 4'h0, 2'd0), '0, "R8 read B after writeback");
      check("R8 B refilled", 32'(fills), 32'd7);
      check("R5 clean E replaced", 32'(wbs), 32'd1);

      // write miss
      issue(1'b1, mk(8'h06, 4'h5, 2'd2), 32'h12345678, "R7 write miss F");
      check("R7 write miss fills", 32'(fills), 32'd8);
      issue(1'b0, mk(8'h06, 4'h5, 2'd2), '0, "R7 read merged word");
      issue(1'b0, mk(8'h06, 4'h5, 2'd1), '0, "R7 read untouched word");
      check("R7 merged line hits", 32'(fills), 32'd8);

      // mixed traffic over two sets and four tags
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         issue(lf[3:0] < 4'd6, mk({6'd0, lf[5:4]}, {3'd0, lf[6]}, lf[8:7]),
               {lf, lf ^ 16'h5A5A}, "R8 mixed read");
      end

      check("R9 memory hold and busy", 32'(r9_bad), 32'd0);
      check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule